// File: doc/BRIEF.md
# Illegal-Opcode Exception Sequencer

This block models the instruction sequencing of a small three-stage (fetch, decode, execute) signal-processing core. It owns the program counter and reports the contents of each stage every cycle. Program memory is outside the block: the block presents a fetch address, and the memory returns two flags for the word at that address, one marking an illegal opcode and one marking a single-instruction repeat.

An illegal opcode is detected when it reaches decode. The exception then becomes pending, and the word behind it in fetch is discarded. Two illegal-vector words are inserted into the fetch stream. The block pushes a return address when the first of those words reaches execute. That address depends on the corner case: an illegal word inside a regular interrupt's two-word vector slot, an illegal word directly after a repeat, or an ordinary illegal word. A regular interrupt request also inserts a two-word vector and then resumes automatically. A hardware loop engine counts fetches of the loop-end address. Because of this, a loop-end word that an interrupt discards and that is later refetched costs two counts.

Top module: `illop_seq`

## Requirements
- R1: While reset is high, all three stages hold bubbles, nothing is pending, the push strobe is low, the loop is inactive, the loop count is zero and the fetch address is RESET_PC.
- R2: With no exception or interrupt, consecutive addresses are fetched, and every word occupies fetch, decode and execute for exactly one cycle each, in that order.
- R3: When irq_req is sampled high and the following hold, the word in fetch is discarded and the next two fetches are VEC_IRQ and VEC_IRQ+1 with kind 1, with vec_fetch high. Fetch then resumes at the discarded word's address with kind 0. The conditions are: fetch holds a kind-0 word, no exception is pending, no interrupt vector is in progress, and decode does not hold a repeat word.
- R4: When a word with the illegal flag (in_ill=1) of kind 0 or 1 is in decode, the following happen in the next cycle. ill_pending rises. Decode and execute hold bubbles, so the illegal word is not executed. Fetch holds VEC_ILL with kind 2. In the cycle after that, fetch holds VEC_ILL+1. Sequential fetch then continues from VEC_ILL+2 with kind 0. ill_pending falls in the cycle after the push.
- R5: push is high for exactly one cycle, when VEC_ILL is in execute. In the ordinary case this is three cycles after the illegal word was in decode, and push_addr equals the illegal word's own address.
- R6: If the illegal word is one of the two interrupt vector words (kind 1), push_addr is the return address of that interrupt, which is the address of the word the interrupt discarded.
- R7: If the illegal word in decode directly follows a repeat word (in_rep=1) that is then in execute, the next cycle shows the illegal word in execute with e_nop=1, and decode and fetch hold bubbles. Fetch holds bubbles for three more cycles, then VEC_ILL (five cycles after decode). push rises two cycles later with push_addr equal to the illegal address plus two.
- R8: With the loop active, each kind-0 fetch of loop_end decrements lc by one and redirects the next fetch to loop_start when lc is above 1. When lc is 1, the loop ends instead: lc is unchanged, loop_active falls and fetch continues at loop_end+1. lc never changes by more than one per cycle.
- R9: A loop-end word that an interrupt discards is counted at its first fetch and counted again when it is refetched after the interrupt vector. lc therefore drops by two for that iteration.
- R10: irq_req has no effect while an illegal exception is pending or being detected, or while decode holds a repeat word. The fetch stream continues as if no request were present.
- R11: A loop_go pulse loads lc from lc_init and sets loop_active when lc_init is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | AW | Address being fetched this cycle |
| in_ill | input | 1 | Word at fetch_pc is an illegal opcode |
| in_rep | input | 1 | Word at fetch_pc is a single-instruction repeat |
| irq_req | input | 1 | Regular interrupt request |
| loop_go | input | 1 | Start a hardware loop |
| lc_init | input | LCW | Loop count loaded by loop_go |
| loop_start | input | AW | First address of the loop body |
| loop_end | input | AW | Last address of the loop body |
| f_valid | output | 1 | Fetch stage holds a word |
| f_addr | output | AW | Address of the fetch-stage word |
| f_kind | output | 2 | Fetch word kind: 0 program, 1 interrupt vector, 2 illegal vector |
| d_valid | output | 1 | Decode stage holds a word |
| d_addr | output | AW | Address of the decode-stage word |
| d_kind | output | 2 | Decode word kind |
| e_valid | output | 1 | Execute stage holds a word |
| e_addr | output | AW | Address of the execute-stage word |
| e_kind | output | 2 | Execute word kind |
| e_nop | output | 1 | Execute word runs as a repeated no-operation |
| vec_fetch | output | 1 | Current fetch is a vector word |
| ill_pending | output | 1 | Illegal exception pending until its push |
| push | output | 1 | Return-address push strobe |
| push_addr | output | AW | Return address being pushed |
| lc | output | LCW | Loop count |
| loop_active | output | 1 | Hardware loop running |

## Verification
Some properties are checked on every cycle: push lasts a single cycle and only while the exception is pending; the loop count never rises without a load and never falls by more than one; no interrupt vector word enters fetch while an exception is pending; words move unchanged from decode to execute; an illegal program word reaches execute only as a repeated no-operation. The chosen return address in each corner case can only be shown by the bench's scenarios. The same holds for the exact bubble count after a repeat, the resume point after an interrupt, and the double count at loop end. The bench builds programs with an illegal word at a random place, a random loop length, and interrupts taken at random cycles.

// File: rtl/illop_seq.sv
module illop_seq #(
  parameter int AW = 8,
  parameter int LCW = 8,
  parameter int IDLE_SLOTS = 3,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter logic [AW-1:0] VEC_IRQ = AW'('hE0),
  parameter logic [AW-1:0] VEC_ILL = AW'('hF0)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AW-1:0]  fetch_pc,
  input  logic           in_ill,
  input  logic           in_rep,
  input  logic           irq_req,
  input  logic           loop_go,
  input  logic [LCW-1:0] lc_init,
  input  logic [AW-1:0]  loop_start,
  input  logic [AW-1:0]  loop_end,
  output logic           f_valid,
  output logic [AW-1:0]  f_addr,
  output logic [1:0]     f_kind,
  output logic           d_valid,
  output logic [AW-1:0]  d_addr,
  output logic [1:0]     d_kind,
  output logic           e_valid,
  output logic [AW-1:0]  e_addr,
  output logic [1:0]     e_kind,
  output logic           e_nop,
  output logic           vec_fetch,
  output logic           ill_pending,
  output logic           push,
  output logic [AW-1:0]  push_addr,
  output logic [LCW-1:0] lc,
  output logic           loop_active
);

  localparam logic [1:0] K_PROG = 2'd0;
  localparam logic [1:0] K_IRQ  = 2'd1;
  localparam logic [1:0] K_ILL  = 2'd2;
  localparam int WCW = $clog2(IDLE_SLOTS + 1);

  typedef struct packed {
    logic          v;
    logic [AW-1:0] a;
    logic          ill;
    logic          rep;
    logic [1:0]    k;
  } stg_t;

  typedef enum logic [2:0] {S_BUB, S_SEQ, S_IV0, S_IV1, S_XV0, S_XV1} src_t;
  typedef enum logic [1:0] {X_IDLE, X_WAIT, X_V1} xst_t;

  stg_t fs, ds, es, fnext;
  logic           nop_q;
  logic [AW-1:0]  pc, irq_ret, ill_ret;
  logic           irq_st, busy, lact;
  logic [LCW-1:0] lc_q;
  logic [WCW-1:0] wcnt;
  xst_t           xst;
  src_t           src;

  wire ill_det   = ds.v & ds.ill & (ds.k != K_ILL);
  wire after_rep = es.v & es.rep & (es.k == K_PROG);
  wire irq_take  = irq_req & fs.v & (fs.k == K_PROG) & ~busy & ~irq_st
                   & ~(ds.v & ds.rep) & ~ill_det;
  wire lhit      = (src == S_SEQ) & lact & (pc == loop_end);
  wire lc_more   = lc_q > LCW'(1);

  always_comb begin
    src = S_SEQ;
    if (ill_det)                src = after_rep ? S_BUB : S_XV0;
    else if (xst == X_WAIT)     src = (wcnt == '0) ? S_XV0 : S_BUB;
    else if (xst == X_V1)       src = S_XV1;
    else if (irq_take)          src = S_IV0;
    else if (irq_st)            src = S_IV1;
  end

  always_comb begin
    case (src)
      S_IV0:   fetch_pc = VEC_IRQ;
      S_IV1:   fetch_pc = VEC_IRQ + AW'(1);
      S_XV0:   fetch_pc = VEC_ILL;
      S_XV1:   fetch_pc = VEC_ILL + AW'(1);
      default: fetch_pc = pc;
    endcase
  end

  always_comb begin
    fnext = '0;
    if (src != S_BUB) begin
      fnext.v   = 1'b1;
      fnext.a   = fetch_pc;
      fnext.ill = in_ill;
      fnext.rep = in_rep;
      case (src)
        S_IV0, S_IV1: fnext.k = K_IRQ;
        S_XV0, S_XV1: fnext.k = K_ILL;
        default:      fnext.k = K_PROG;
      endcase
    end
  end

  assign push = es.v & (es.k == K_ILL) & (es.a == VEC_ILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      fs <= '0; ds <= '0; es <= '0; nop_q <= 1'b0;
    end else begin
      fs <= fnext;
      ds <= (ill_det | irq_take) ? '0 : fs;
      if (ill_det) begin
        es    <= after_rep ? '{v: 1'b1, a: ds.a, ill: ds.ill, rep: 1'b0, k: ds.k} : '0;
        nop_q <= after_rep;
      end else begin
        es    <= ds;
        nop_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else begin
      case (src)
        S_SEQ:   pc <= (lhit && lc_more) ? loop_start : pc + AW'(1);
        S_IV0:   pc <= fs.a;
        S_XV1:   pc <= VEC_ILL + AW'(2);
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lc_q <= '0; lact <= 1'b0;
    end else if (loop_go) begin
      lc_q <= lc_init;
      lact <= (lc_init != '0);
    end else if (lhit) begin
      if (lc_more) lc_q <= lc_q - LCW'(1);
      else         lact <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_st <= 1'b0; irq_ret <= '0;
    end else begin
      if (ill_det)            irq_st <= 1'b0;
      else if (src == S_IV0)  irq_st <= 1'b1;
      else if (src == S_IV1)  irq_st <= 1'b0;
      if (irq_take) irq_ret <= fs.a;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; ill_ret <= '0; xst <= X_IDLE; wcnt <= '0;
    end else if (ill_det) begin
      busy <= 1'b1;
      if (ds.k == K_IRQ)  ill_ret <= irq_ret;
      else if (after_rep) ill_ret <= ds.a + AW'(2);
      else                ill_ret <= ds.a;
      xst  <= after_rep ? X_WAIT : X_V1;
      wcnt <= WCW'(IDLE_SLOTS);
    end else begin
      if (push) busy <= 1'b0;
      case (xst)
        X_WAIT:  if (wcnt == '0) xst <= X_V1; else wcnt <= wcnt - WCW'(1);
        X_V1:    xst <= X_IDLE;
        default: xst <= X_IDLE;
      endcase
    end
  end

  assign f_valid = fs.v;  assign f_addr = fs.a;  assign f_kind = fs.k;
  assign d_valid = ds.v;  assign d_addr = ds.a;  assign d_kind = ds.k;
  assign e_valid = es.v;  assign e_addr = es.a;  assign e_kind = es.k;
  assign e_nop = nop_q;
  assign vec_fetch = (src != S_BUB) && (src != S_SEQ);
  assign ill_pending = busy;
  assign push_addr = ill_ret;
  assign lc = lc_q;
  assign loop_active = lact;

  assert_push_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);
  assert_push_pending_R4: assert property (@(posedge clk) disable iff (rst)
    push |-> busy);
  assert_stage_flow_R2: assert property (@(posedge clk) disable iff (rst)
    (ds.v && !ill_det && !irq_take) |=> (es.v && es.a == $past(ds.a)));
  assert_lc_no_rise_R11: assert property (@(posedge clk) disable iff (rst)
    !loop_go |=> (lc_q <= $past(lc_q)));
  assert_lc_step_R8: assert property (@(posedge clk) disable iff (rst)
    !loop_go |=> (($past(lc_q) - lc_q) <= LCW'(1)));
  assert_irq_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(fs.v && fs.k == K_IRQ));
  assert_rep_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    nop_q |-> (!ds.v && !fs.v));
  assert_no_exec_R4: assert property (@(posedge clk) disable iff (rst)
    (es.v && es.ill && es.k != K_ILL) |-> nop_q);

endmodule

// File: tb/illop_seq_tb_top.sv
module illop_seq_tb_top;
  localparam int AW = 8;
  localparam int LCW = 8;
  localparam logic [AW-1:0] VIRQ = 8'hE0;
  localparam logic [AW-1:0] VILL = 8'hF0;

  logic clk = 1'b0, rst = 1'b1;
  logic irq_req = 1'b0, loop_go = 1'b0;
  logic [LCW-1:0] lc_init = '0;
  logic [AW-1:0] loop_start = 8'd200, loop_end = 8'd201;
  logic [AW-1:0] fetch_pc, f_addr, d_addr, e_addr, push_addr;
  logic [1:0] f_kind, d_kind, e_kind;
  logic f_valid, d_valid, e_valid, e_nop, vec_fetch, ill_pending, push, loop_active;
  logic [LCW-1:0] lc;
  logic mem_ill [256];
  logic mem_rep [256];
  logic in_ill, in_rep;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign in_ill = mem_ill[fetch_pc];
  assign in_rep = mem_rep[fetch_pc];

  illop_seq #(.AW(AW), .LCW(LCW), .IDLE_SLOTS(3), .RESET_PC('0),
              .VEC_IRQ(VIRQ), .VEC_ILL(VILL)) dut_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .in_ill(in_ill), .in_rep(in_rep),
    .irq_req(irq_req), .loop_go(loop_go), .lc_init(lc_init),
    .loop_start(loop_start), .loop_end(loop_end),
    .f_valid(f_valid), .f_addr(f_addr), .f_kind(f_kind),
    .d_valid(d_valid), .d_addr(d_addr), .d_kind(d_kind),
    .e_valid(e_valid), .e_addr(e_addr), .e_kind(e_kind), .e_nop(e_nop),
    .vec_fetch(vec_fetch), .ill_pending(ill_pending), .push(push),
    .push_addr(push_addr), .lc(lc), .loop_active(loop_active));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ret_plain(input int a);
    return a;
  endfunction
  function automatic int ret_after_rep(input int a);
    return (a + 2) % 256;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      mem_ill[i] = 1'b0;
      mem_rep[i] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_req = 1'b0; loop_go = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_dec(input int a, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      if (d_valid && d_addr == a[AW-1:0] && d_kind == 2'd0) ok = 1'b1;
    end
    if (!ok) chk(1'b0, "R4 decode reached", 0, a);
  endtask

  task automatic wait_push(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200 && !ok; i++) begin
      @(negedge clk);
      if (push) ok = 1'b1;
    end
    if (!ok) chk(1'b0, "R5 push seen", 0, 1);
  endtask

  task automatic run_ill(input int a, input bit rep);
    bit ok;
    clear_mem();
    mem_ill[a] = 1'b1;
    if (rep) mem_rep[a-1] = 1'b1;
    do_reset();
    wait_dec(a, ok);
    if (!ok) return;
    if (!rep) begin
      @(negedge clk);
      chk(ill_pending, "R4 pending", int'(ill_pending), 1);
      chk(!d_valid && !e_valid, "R4 squash", int'({d_valid, e_valid}), 0);
      chk(f_valid && f_addr == VILL && f_kind == 2'd2, "R4 vec0", int'(f_addr), int'(VILL));
      @(negedge clk);
      chk(f_addr == VILL + 1 && f_kind == 2'd2, "R4 vec1", int'(f_addr), int'(VILL) + 1);
      @(negedge clk);
      chk(push && push_addr == ret_plain(a), "R5 push addr", int'(push_addr), a);
      chk(f_addr == VILL + 2 && f_kind == 2'd0, "R4 resume", int'(f_addr), int'(VILL) + 2);
      @(negedge clk);
      chk(!push && !ill_pending, "R5 single push", int'({push, ill_pending}), 0);
    end else begin
      @(negedge clk);
      chk(e_valid && e_nop && e_addr == a, "R7 nop exec", int'(e_addr), a);
      chk(!d_valid && !f_valid, "R7 bubbles", int'({d_valid, f_valid}), 0);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!f_valid, "R7 idle fetch", int'(f_valid), 0);
      end
      @(negedge clk);
      chk(f_valid && f_addr == VILL, "R7 vec0 timing", int'(f_addr), int'(VILL));
      @(negedge clk);
      chk(!push, "R7 no early push", int'(push), 0);
      @(negedge clk);
      chk(push && push_addr == ret_after_rep(a), "R7 push addr", int'(push_addr), ret_after_rep(a));
    end
  endtask

  task automatic run_irq(input int k);
    logic [AW-1:0] w;
    clear_mem();
    do_reset();
    repeat (k) @(negedge clk);
    w = f_addr;
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    chk(f_addr == VIRQ && f_kind == 2'd1 && !d_valid, "R3 vec0", int'(f_addr), int'(VIRQ));
    @(negedge clk);
    chk(f_addr == VIRQ + 1 && f_kind == 2'd1 && vec_fetch == 1'b0, "R3 vec1", int'(f_addr), int'(VIRQ) + 1);
    @(negedge clk);
    chk(f_addr == w && f_kind == 2'd0, "R3 resume", int'(f_addr), int'(w));
  endtask

  task automatic run_loop(input int s, input int e, input int n);
    int cnt = 0;
    bit first = 1'b1, check_next = 1'b0, done = 1'b0;
    clear_mem();
    loop_start = s[AW-1:0]; loop_end = e[AW-1:0];
    do_reset();
    lc_init = n[LCW-1:0]; loop_go = 1'b1;
    @(negedge clk);
    loop_go = 1'b0;
    chk(loop_active && lc == n, "R11 load", int'(lc), n);
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      if (check_next) begin
        check_next = 1'b0;
        chk(f_addr == ((n > 1) ? s : e + 1), "R8 redirect", int'(f_addr), (n > 1) ? s : e + 1);
      end
      if (f_valid && f_kind == 2'd0 && f_addr == e) begin
        cnt++;
        if (first) begin first = 1'b0; check_next = 1'b1; end
      end
      if (f_valid && f_addr == e + 1) done = 1'b1;
    end
    chk(cnt == n, "R8 end fetch count", cnt, n);
    chk(lc == 1 && !loop_active, "R8 terminate", int'(lc), 1);
    loop_start = 8'd200; loop_end = 8'd201;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    logic [AW-1:0] w, a;
    void'($urandom(32'd1234));
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!f_valid && !d_valid && !e_valid, "R1 stages empty", int'({f_valid, d_valid, e_valid}), 0);
    chk(!ill_pending && !push && !loop_active && lc == 0, "R1 state", int'(lc), 0);
    chk(fetch_pc == 0, "R1 fetch pc", int'(fetch_pc), 0);

    rst = 1'b0;
    repeat (4) @(negedge clk);
    a = f_addr;
    @(negedge clk);
    chk(d_addr == a && f_addr == a + 1, "R2 fetch to decode", int'(d_addr), int'(a));
    @(negedge clk);
    chk(e_addr == a && e_valid && !e_nop, "R2 decode to execute", int'(e_addr), int'(a));

    run_ill(25, 1'b0);
    run_ill(40, 1'b1);
    for (int i = 0; i < 6; i++) run_ill(12 + int'($urandom % 50), bit'($urandom % 2));

    run_irq(5);
    for (int i = 0; i < 3; i++) run_irq(3 + int'($urandom % 30));

    run_loop(12, 15, 4);
    run_loop(20, 20, 1);
    for (int i = 0; i < 3; i++) begin
      int s = 10 + int'($urandom % 10);
      run_loop(s, s + 1 + int'($urandom % 5), 1 + int'($urandom % 6));
    end

    clear_mem();
    mem_ill[VIRQ] = 1'b1;
    do_reset();
    repeat (8) @(negedge clk);
    w = f_addr;
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    wait_push(ok);
    if (ok) chk(push_addr == w, "R6 vector slot return", int'(push_addr), int'(w));

    clear_mem();
    mem_ill[13] = 1'b1;
    loop_start = 8'd10; loop_end = 8'd13;
    do_reset();
    lc_init = 8'd5; loop_go = 1'b1;
    @(negedge clk);
    loop_go = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 100 && !ok; i++) begin
      @(negedge clk);
      if (f_valid && f_addr == 8'd13 && d_valid && d_addr == 8'd12) ok = 1'b1;
    end
    chk(ok && lc == 4, "R8 first loop-end fetch", int'(lc), 4);
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    wait_push(ok);
    if (ok) begin
      chk(push_addr == 13, "R9 return to loop end", int'(push_addr), 13);
      chk(lc == 3, "R9 double decrement", int'(lc), 3);
    end
    loop_start = 8'd200; loop_end = 8'd201;

    clear_mem();
    mem_ill[30] = 1'b1;
    do_reset();
    wait_dec(30, ok);
    irq_req = 1'b1;
    @(negedge clk);
    chk(f_addr == VILL && f_kind == 2'd2, "R10 ignored at detect", int'(f_addr), int'(VILL));
    @(negedge clk);
    chk(f_addr == VILL + 1 && f_kind == 2'd2, "R10 ignored pending", int'(f_addr), int'(VILL) + 1);
    @(negedge clk);
    irq_req = 1'b0;
    chk(f_addr == VILL + 2 && f_kind == 2'd0, "R10 no irq vector", int'(f_kind), 0);
    @(negedge clk);
    chk(f_kind == 2'd0 && f_addr == VILL + 3, "R10 stream intact", int'(f_addr), int'(VILL) + 3);

    clear_mem();
    mem_rep[20] = 1'b1;
    do_reset();
    wait_dec(20, ok);
    irq_req = 1'b1;
    @(negedge clk);
    chk(f_addr == 22 && f_kind == 2'd0 && d_addr == 21 && d_valid, "R10 repeat blocks irq", int'(f_addr), 22);
    irq_req = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule